// File: doc/BRIEF.md
# Mode-Aware Address Arithmetic Unit

This unit computes the next value of a program counter, a stack pointer or a general address register for a 32-bit processor core. Each request carries an operation code, a 32-bit base and a 16-bit offset. The unit returns a registered 32-bit result, and the full 32 bits of that result go to the external address bus.

A sticky mode flag sets the width of the arithmetic. After reset the unit is in narrow mode. In narrow mode only the low 16 bits take part in the sum, and the upper 16 bits of the base are copied to the result unchanged. Code therefore stays inside a 64 KB window, while data above that window can still be reached through high words that were loaded explicitly. A one-shot widen command switches the unit to wide mode, where the whole 32-bit value takes part in the sum. Only reset brings the unit back to narrow mode.

Top module: `addr_arith_unit`

## Requirements
- R1: While reset is asserted and after it is released, `wide_mode` is 0, `res_valid` is 0 and `res_addr` is 0.
- R2: In narrow mode, `res_addr[15:0]` equals the low 16 bits of the base plus the step, taken modulo 65536. Any carry or borrow out of bit 15 is discarded.
- R3: In narrow mode, `res_addr[31:16]` equals `base_addr[31:16]` of the same request. This holds for every operation code.
- R4: In wide mode, `res_addr` equals the base plus the step sign-extended to 32 bits, taken modulo 2^32.
- R5: The step depends on `op_sel`:
  - 0: increment, step +1.
  - 1: decrement, step −1.
  - 2: add, step +offset.
  - 3: subtract, step −offset.
  - 4: indexed, step +offset.
  - 5: stack-relative, step +offset.
  - 6: PC-relative, step +offset.
  - In every case the offset is a 16-bit two's-complement value.
- R6: A pulse on `widen_req` sets `wide_mode` at the next clock edge. A request issued in the same cycle as the pulse still uses narrow mode, and the request in the following cycle uses wide mode.
- R7: `wide_mode` is sticky. Asserting `widen_req` again while in wide mode changes nothing, and only reset returns the unit to narrow mode.
- R8: A request accepted with `req_valid` high drives `res_valid` high with its result one cycle later. In a cycle with `req_valid` low, `res_valid` is low in the next cycle and `res_addr` keeps its value.
- R9: Operation code 7 is reserved and has a step of zero, so `res_addr` equals `base_addr` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (see R5) |
| base_addr | input | 32 | Base operand |
| offset | input | 16 | Two's-complement offset |
| widen_req | input | 1 | One-shot switch to wide mode |
| res_addr | output | 32 | Registered address result |
| res_valid | output | 1 | Result strobe |
| wide_mode | output | 1 | Current mode, 1 = wide |

## Verification
Every result appears on `res_addr`/`res_valid` exactly one clock edge after its request. The bench therefore drives each request on a falling edge and compares the outputs on the following falling edge. A change of mode shows on `wide_mode` one edge after `widen_req`. The bench checks that edge separately and also issues a request in the same cycle as the widen pulse, so that it can confirm that request still sees the old mode. Sweeps cover low halves near 0x0000, 0x7FFF/0x8000 and 0xFFFF, and offsets 0, ±1 and the extreme values, for all eight codes in both modes.

// File: rtl/aau_pkg.sv
package aau_pkg;
  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_IDX  = 3'd4,
    OP_STK  = 3'd5,
    OP_PCR  = 3'd6,
    OP_RSVD = 3'd7
  } aau_op_e;
endpackage

// File: rtl/aau_mode_latch.sv
module aau_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic widen_req,
  output logic wide_mode,
  output logic widen_event
);
  // widen_event marks the single cycle in which the mode actually changes
  assign widen_event = widen_req && !wide_mode;

  always_ff @(posedge clk) begin
    if (!rst_n)           wide_mode <= 1'b0;
    else if (widen_event) wide_mode <= 1'b1;
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |=> wide_mode);
  p_set_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    widen_req |=> wide_mode);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!widen_req && !wide_mode) |=> !wide_mode);
endmodule

// File: rtl/aau_step_gen.sv
module aau_step_gen
  import aau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  aau_op_e           op,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] step
);
  localparam int EXT_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] sext(input logic [OFF_W-1:0] v);
    return {{EXT_W{v[OFF_W-1]}}, v};
  endfunction

  always_comb begin
    unique case (op)
      OP_INC:                 step = ADDR_W'(1);
      OP_DEC:                 step = '1;
      OP_ADD, OP_IDX,
      OP_STK, OP_PCR:         step = sext(offset);
      OP_SUB:                 step = '0 - sext(offset);
      default:                step = '0;
    endcase
  end
endmodule

// File: rtl/aau_wrap_add.sv
module aau_wrap_add #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic              wide,
  output logic [ADDR_W-1:0] sum
);
  localparam int HI_W = ADDR_W - NARROW_W;

  // Narrow sum: low field wraps on its own, high field is copied through
  function automatic logic [ADDR_W-1:0] narrow_add(
    input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s);
    logic [NARROW_W-1:0] lo;
    lo = b[NARROW_W-1:0] + s[NARROW_W-1:0];
    return {b[ADDR_W-1:NARROW_W], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] wide_add(
    input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s);
    return b + s;
  endfunction

  logic [ADDR_W-1:0] sum_narrow, sum_wide;
  assign sum_narrow = narrow_add(base, step);
  assign sum_wide   = wide_add(base, step);
  assign sum        = wide ? sum_wide : sum_narrow;

  initial begin
    assert (HI_W > 0) else $error("narrow width must be below address width");
  end
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
  import aau_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int OFF_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        op_sel,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic              widen_req,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_valid,
  output logic              wide_mode
);
  logic              widen_event;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] next_addr;

  aau_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .widen_req  (widen_req),
    .wide_mode  (wide_mode),
    .widen_event(widen_event)
  );

  aau_step_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_step (
    .op    (aau_op_e'(op_sel)),
    .offset(offset),
    .step  (step)
  );

  aau_wrap_add #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_add (
    .base(base_addr),
    .step(step),
    .wide(wide_mode),
    .sum (next_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_addr  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_addr <= next_addr;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !wide_mode && res_addr == '0));
  p_upper_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wide_mode) |=>
      res_addr[ADDR_W-1:NARROW_W] == $past(base_addr[ADDR_W-1:NARROW_W]));
  p_narrow_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wide_mode) |=>
      res_addr[NARROW_W-1:0] ==
        $past(NARROW_W'(base_addr[NARROW_W-1:0] + step[NARROW_W-1:0])));
  p_wide_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wide_mode) |=> res_addr == $past(ADDR_W'(base_addr + step)));
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(res_addr)));
  p_rsvd_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel == 3'd7) |=> res_addr == $past(base_addr));
  p_switch_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    widen_event |=> !widen_event);
endmodule

// File: tb/test_addr_arith_unit.sv
module test_addr_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] base_addr = '0;
  logic [15:0] offset = '0;
  logic        widen_req = 1'b0;
  logic [31:0] res_addr;
  logic        res_valid;
  logic        wide_mode;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  addr_arith_unit i_addr_arith_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_sel(op_sel),
    .base_addr(base_addr), .offset(offset), .widen_req(widen_req),
    .res_addr(res_addr), .res_valid(res_valid), .wide_mode(wide_mode)
  );

  // Reference model restated from R2..R5, R9
  function automatic logic [31:0] model(input int op, input logic [31:0] b,
                                        input logic [15:0] o, input bit wide);
    longint s;
    longint d;
    longint t;
    s = longint'($signed(o));
    case (op)
      0: d = 1;
      1: d = -1;
      3: d = -s;
      7: d = 0;
      default: d = s;
    endcase
    if (wide) begin
      t = longint'(b) + d;
      return t[31:0];
    end
    t = longint'(b[15:0]) + d;
    return {b[31:16], t[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request: drive on falling edge, compare on the next falling edge
  task automatic issue(input int op, input logic [31:0] b, input logic [15:0] o,
                       input bit wide, input string req);
    @(negedge clk);
    req_valid = 1'b1; op_sel = 3'(op); base_addr = b; offset = o;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {31'd0, res_valid}, 32'd1);
    check(req, res_addr, model(op, b, o, wide));
  endtask

  task automatic sweep(input bit wide);
    logic [15:0] lows [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    logic [15:0] highs[3] = '{16'h0000, 16'h1234, 16'hFFFF};
    logic [15:0] offs [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00A5};
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 6; l++)
        for (int f = 0; f < 6; f++)
          for (int op = 0; op < 8; op++)
            issue(op, {highs[h], lows[l]}, offs[f], wide,
                  wide ? "R4/R5/R9 wide" : "R2/R3/R5/R9 narrow");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset wide_mode", {31'd0, wide_mode}, 32'd0);
    check("R1 reset res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 reset res_addr", res_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'd0, wide_mode}, 32'd0);

    // R2 carry discarded, R3 high word kept
    issue(0, 32'h0005_FFFF, 16'h0000, 1'b0, "R2 inc wrap");
    issue(1, 32'h0005_0000, 16'h0000, 1'b0, "R2 dec wrap");
    sweep(1'b0);

    // R8 idle: no valid, result held
    @(negedge clk);
    check("R8 idle valid", {31'd0, res_valid}, 32'd0);
    check("R8 idle hold", res_addr, model(7, 32'hFFFF_FFFF, 16'h00A5, 1'b0));

    // R6 request in the widen cycle still narrow
    @(negedge clk);
    widen_req = 1'b1; req_valid = 1'b1; op_sel = 3'd0; base_addr = 32'h0000_FFFF;
    @(negedge clk);
    widen_req = 1'b0; req_valid = 1'b0;
    check("R6 same-cycle narrow", res_addr, 32'h0000_0000);
    check("R6 mode set", {31'd0, wide_mode}, 32'd1);
    issue(0, 32'h0000_FFFF, 16'h0000, 1'b1, "R6 next wide");

    // R7 repeated widen has no effect
    @(negedge clk); widen_req = 1'b1;
    @(negedge clk); widen_req = 1'b0;
    check("R7 still wide", {31'd0, wide_mode}, 32'd1);
    sweep(1'b1);

    // R7 only reset clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R7/R1 reset clears mode", {31'd0, wide_mode}, 32'd0);
    rst_n = 1'b1;
    issue(0, 32'h0001_FFFF, 16'h0000, 1'b0, "R7 narrow after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule